// File: doc/BRIEF.md
# Preamble False-Detect Supervisor

This block watches the radio's interrupt status, which a command engine reads at regular intervals and hands over as one status byte per sample. From each sample it derives a carrier-present indication: the carrier counts as present whenever the sample shows either a detected preamble or a detected header. While a preamble is showing, the block times how long it has been seen, counted in whole milliseconds against an external millisecond tick.

The first sample that shows a preamble stamps the current millisecond count. The stamp stays in place until the window closes. The window closes on a preamble sample whose elapsed time is strictly greater than the sum of two programmable durations: the expected preamble time and the expected header time. When the window closes, the block drops the stamp and asks the command engine to clear the preamble interrupt. If that closing sample also shows no header, the preamble is taken as false. The block then follows the clear with a request that restarts the receiver in continuous mode.

Requests leave as a byte stream with a valid/ready handshake. A last-byte marker ends each command, so the command engine can frame each one as a single bus transaction.

Top module: `pfd_supervisor`

## Requirements
- R1: After reset `carrier_present` is 0 and `cmd_valid` is 0. On every clock where `stat_valid` is high, `carrier_present` takes the value (bit 4 OR bit 2) of `stat_byte` on the next clock, and holds that value while no sample arrives.
- R2: Bits 0, 1, 3, 5, 6 and 7 of `stat_byte` have no effect on `carrier_present`, on the timing or on the command stream.
- R3: When no stamp is held, a sample with bit 2 set stamps the current millisecond count. Later samples with bit 2 set do not move the stamp. Samples with bit 2 clear neither move nor drop it.
- R4: A sample with bit 2 set, taken while a stamp is held, closes the window when (ticks since the stamp) > `pre_ms` + `hdr_ms`. Closing emits the clear command, bytes 0x02, 0x00, 0x04 in that order, and drops the stamp. The next bit-2 sample then starts a fresh window.
- R5: If bit 4 is clear in the sample that closes the window, the clear command is followed by the receive-restart command, bytes 0x82, 0xFF, 0xFF, 0xFF in that order.
- R6: If bit 4 is set in the sample that closes the window, only the clear command is emitted.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_byte` and `cmd_last` hold steady. `cmd_last` is high exactly on the final byte of each command (0x04 of the clear, the third 0xFF of the restart). Each command begins with `cmd_valid` rising on its opcode byte.
- R8: The millisecond count advances by one on each clock with `ms_tick` high and never takes the value zero, so a held stamp is always non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per elapsed millisecond |
| stat_valid | input | 1 | A new interrupt status sample is present |
| stat_byte | input | 8 | Low status byte: bit 4 header seen, bit 2 preamble seen |
| pre_ms | input | MS_W | Expected preamble duration in ms |
| hdr_ms | input | MS_W | Expected header duration in ms |
| carrier_present | output | 1 | Preamble or header seen in the latest sample |
| cmd_valid | output | 1 | A request byte is offered |
| cmd_byte | output | 8 | Request byte |
| cmd_last | output | 1 | Final byte of the current request |
| cmd_ready | input | 1 | Command engine takes the offered byte |

## Verification
The bench builds the block with its default widths: a 16-bit millisecond count and 8-bit duration inputs. It sweeps `pre_ms` over 0 to 3 and `hdr_ms` over 0 to 2, which gives windows of 0 to 5 ms. Within a handful of ticks this reaches every boundary: the last sample that must not close the window and the first that must. The same short windows let each configuration cover both outcomes of a closing sample (header seen or not), re-arming straight after a close, and samples without a preamble in the middle of a window. One further run holds `cmd_ready` low to show that the command stream waits on the engine.

// File: rtl/pfd_pkg.sv
// Shared constants and types for the preamble false-detect supervisor.
// Assumes the status byte layout of the radio: header bit 4, preamble bit 2.
package pfd_pkg;
    localparam int HDR_BIT = 4;
    localparam int PRE_BIT = 2;

    localparam logic [7:0] OP_CLR_IRQ = 8'h02;
    localparam logic [7:0] CLR_MASK_H = 8'h00;
    localparam logic [7:0] CLR_MASK_L = 8'(1 << PRE_BIT);
    localparam logic [7:0] OP_RX      = 8'h82;
    localparam logic [7:0] RX_TMO     = 8'hFF;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_C0,
        SEQ_C1,
        SEQ_C2,
        SEQ_R0,
        SEQ_R1,
        SEQ_R2,
        SEQ_R3
    } seq_t;
endpackage

// File: rtl/pfd_ms_clock.sv
// Millisecond counter. Advances once per ms_tick and skips zero on wrap,
// so zero can serve as the "no stamp" marker downstream.
// Assumes ms_tick is a single-clock pulse.
module pfd_ms_clock #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    output logic [TIME_W-1:0] now
);
    localparam logic [TIME_W-1:0] T_ONE = TIME_W'(1);
    localparam logic [TIME_W-1:0] T_MAX = '1;

    // Count ticks, restarting at one after the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= T_ONE;
        else if (ms_tick)
            now <= (now == T_MAX) ? T_ONE : now + T_ONE;
    end
endmodule

// File: rtl/pfd_window.sv
// Preamble window timer. Holds the stamp of the first preamble sample and
// decides, on each later preamble sample, whether the allowed window has run
// out. A zero stamp means no preamble is pending.
// Assumes the window limit stays well below half the counter range.
module pfd_window #(
    parameter int TIME_W = 16,
    parameter int LIM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_pre,
    input  logic              smp_hdr,
    input  logic [TIME_W-1:0] now,
    input  logic [LIM_W-1:0]  limit,
    output logic              expire,
    output logic              false_pre
);
    localparam int CMP_W = (TIME_W > LIM_W) ? TIME_W : LIM_W;

    logic [TIME_W-1:0] stamp;
    logic [TIME_W-1:0] elapsed;
    logic [CMP_W-1:0]  el_x;
    logic [CMP_W-1:0]  lim_x;
    logic              armed;
    logic              pre_smp;

    // Elapsed time since the stamp, widened for comparison.
    always_comb begin
        armed   = (stamp != '0);
        pre_smp = smp_valid && smp_pre;
        elapsed = now - stamp;
        el_x    = CMP_W'(elapsed);
        lim_x   = CMP_W'(limit);
    end

    // Window closes only on a preamble sample past the limit.
    always_comb begin
        expire    = pre_smp && armed && (el_x > lim_x);
        false_pre = expire && !smp_hdr;
    end

    // Stamp the first preamble sample; drop the stamp on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stamp <= '0;
        else if (expire)
            stamp <= '0;
        else if (pre_smp && !armed)
            stamp <= now;
    end
endmodule

// File: rtl/pfd_cmd_seq.sv
// Command sequencer. Turns clear and restart requests into byte streams with
// a valid/ready handshake. Requests that arrive while busy are remembered
// and merged; a pending clear is always sent before a pending restart.
module pfd_cmd_seq
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_clr,
    input  logic       req_rx,
    input  logic       cmd_ready,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    output logic       cmd_last
);
    seq_t state, nxt;
    logic clr_pend, rx_pend;
    logic clr_any, rx_any, take_clr, take_rx, accept;

    // Request bookkeeping and dispatch decisions.
    always_comb begin
        clr_any  = clr_pend || req_clr;
        rx_any   = rx_pend || req_rx;
        take_clr = (state == SEQ_IDLE) && clr_any;
        take_rx  = (state == SEQ_IDLE) && !clr_any && rx_any;
        accept   = cmd_valid && cmd_ready;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            SEQ_IDLE: begin
                if (take_clr)     nxt = SEQ_C0;
                else if (take_rx) nxt = SEQ_R0;
            end
            SEQ_C0: if (accept) nxt = SEQ_C1;
            SEQ_C1: if (accept) nxt = SEQ_C2;
            SEQ_C2: if (accept) nxt = SEQ_IDLE;
            SEQ_R0: if (accept) nxt = SEQ_R1;
            SEQ_R1: if (accept) nxt = SEQ_R2;
            SEQ_R2: if (accept) nxt = SEQ_R3;
            SEQ_R3: if (accept) nxt = SEQ_IDLE;
            default: nxt = SEQ_IDLE;
        endcase
    end

    // Byte presented for each state.
    always_comb begin
        cmd_valid = (state != SEQ_IDLE);
        cmd_last  = (state == SEQ_C2) || (state == SEQ_R3);
        case (state)
            SEQ_C0:  cmd_byte = OP_CLR_IRQ;
            SEQ_C1:  cmd_byte = CLR_MASK_H;
            SEQ_C2:  cmd_byte = CLR_MASK_L;
            SEQ_R0:  cmd_byte = OP_RX;
            SEQ_R1,
            SEQ_R2,
            SEQ_R3:  cmd_byte = RX_TMO;
            default: cmd_byte = 8'h00;
        endcase
    end

    // State and pending-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            clr_pend <= 1'b0;
            rx_pend  <= 1'b0;
        end else begin
            state    <= nxt;
            clr_pend <= clr_any && !take_clr;
            rx_pend  <= rx_any && !take_rx;
        end
    end
endmodule

// File: rtl/pfd_supervisor.sv
// Preamble false-detect supervisor, top level. Derives carrier-present from
// each status sample, times preamble detections against a millisecond tick
// and requests an interrupt clear, plus a receiver restart when the preamble
// turns out false. Assumes samples and ticks are single-clock pulses.
module pfd_supervisor
    import pfd_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int MS_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            stat_valid,
    input  logic [7:0]      stat_byte,
    input  logic [MS_W-1:0] pre_ms,
    input  logic [MS_W-1:0] hdr_ms,
    output logic            carrier_present,
    output logic            cmd_valid,
    output logic [7:0]      cmd_byte,
    output logic            cmd_last,
    input  logic            cmd_ready
);
    localparam int LIM_W = MS_W + 1;

    logic [TIME_W-1:0] now;
    logic [LIM_W-1:0]  limit;
    logic              hdr_seen, pre_seen;
    logic              expire, false_pre;
    logic              unused_bits;

    // Decode the two status bits that matter and the window limit.
    always_comb begin
        hdr_seen    = stat_byte[HDR_BIT];
        pre_seen    = stat_byte[PRE_BIT];
        limit       = LIM_W'(pre_ms) + LIM_W'(hdr_ms);
        unused_bits = ^stat_byte;
    end

    // Carrier flag follows the latest sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carrier_present <= 1'b0;
        else if (stat_valid)
            carrier_present <= hdr_seen || pre_seen;
    end

    pfd_ms_clock #(.TIME_W(TIME_W)) clock_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .now     (now)
    );

    pfd_window #(.TIME_W(TIME_W), .LIM_W(LIM_W)) window_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (stat_valid),
        .smp_pre   (pre_seen),
        .smp_hdr   (hdr_seen),
        .now       (now),
        .limit     (limit),
        .expire    (expire),
        .false_pre (false_pre)
    );

    pfd_cmd_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_clr   (expire),
        .req_rx    (false_pre),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd_last  (cmd_last)
    );
endmodule

// File: rtl/pfd_supervisor_chk.sv
// Port-level checker for pfd_supervisor, attached with bind.
module pfd_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_valid,
    input logic [7:0] stat_byte,
    input logic       carrier_present,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       cmd_last,
    input logic       cmd_ready
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !carrier_present));

    // R1
    carrier_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> (carrier_present == ($past(stat_byte[4]) || $past(stat_byte[2]))));

    // R1
    carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |=> $stable(carrier_present));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_last)));

    // R7
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> (cmd_byte == 8'h02 || cmd_byte == 8'h82));

    // R7
    cmd_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_last) |-> (cmd_byte == 8'h04 || cmd_byte == 8'hFF));
endmodule

bind pfd_supervisor pfd_supervisor_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .stat_valid      (stat_valid),
    .stat_byte       (stat_byte),
    .carrier_present (carrier_present),
    .cmd_valid       (cmd_valid),
    .cmd_byte        (cmd_byte),
    .cmd_last        (cmd_last),
    .cmd_ready       (cmd_ready)
);

// File: tb/pfd_supervisor_tb_top.sv
// Sweep bench for pfd_supervisor over small window settings.
module pfd_supervisor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       stat_valid = 1'b0;
    logic [7:0] stat_byte = 8'h00;
    logic [7:0] pre_ms = 8'd0;
    logic [7:0] hdr_ms = 8'd0;
    logic       carrier_present, cmd_valid, cmd_last;
    logic [7:0] cmd_byte;
    logic       cmd_ready = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] got_b[$];
    logic       got_l[$];

    always #4 clk = ~clk;

    pfd_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .stat_valid(stat_valid), .stat_byte(stat_byte),
        .pre_ms(pre_ms), .hdr_ms(hdr_ms),
        .carrier_present(carrier_present),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .cmd_ready(cmd_ready)
    );

    // Collect accepted bytes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            got_b.push_back(cmd_byte);
            got_l.push_back(cmd_last);
        end
    end

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        got_b.delete();
        got_l.delete();
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic sample(input logic [7:0] b);
        @(negedge clk) begin stat_valid = 1'b1; stat_byte = b; end
        @(negedge clk) stat_valid = 1'b0;
    endtask

    task automatic check_carrier(input logic exp, input string tag);
        total++;
        if (carrier_present !== exp) begin
            bad++;
            $display("FAIL %s carrier_present actual=%0b expected=%0b", tag, carrier_present, exp);
        end
    endtask

    // kind 0: nothing, 1: clear only, 2: clear then restart
    task automatic check_cmds(input int kind, input string tag);
        logic [7:0] eb[$];
        logic       el[$];
        bit ok;
        repeat (16) @(negedge clk);
        if (kind >= 1) begin
            eb.push_back(8'h02); el.push_back(1'b0);
            eb.push_back(8'h00); el.push_back(1'b0);
            eb.push_back(8'h04); el.push_back(1'b1);
        end
        if (kind == 2) begin
            eb.push_back(8'h82); el.push_back(1'b0);
            eb.push_back(8'hFF); el.push_back(1'b0);
            eb.push_back(8'hFF); el.push_back(1'b0);
            eb.push_back(8'hFF); el.push_back(1'b1);
        end
        ok = (got_b.size() == eb.size());
        if (ok) begin
            for (int i = 0; i < eb.size(); i++)
                if (got_b[i] !== eb[i] || got_l[i] !== el[i]) ok = 1'b0;
        end
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s command bytes actual=%p last=%p expected=%p last=%p",
                     tag, got_b, got_l, eb, el);
        end
        got_b.delete();
        got_l.delete();
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            for (int h = 0; h < 3; h++) begin
                int lim;
                bit hdr_close;
                lim = p + h;
                hdr_close = (p % 2 == 1);
                pre_ms = 8'(p);
                hdr_ms = 8'(h);
                do_reset();
                // R1 reset state
                check_carrier(1'b0, "R1 reset");
                total++;
                if (cmd_valid !== 1'b0) begin
                    bad++;
                    $display("FAIL R1 reset cmd_valid actual=%0b expected=0", cmd_valid);
                end
                // R2 other bits ignored, R1 header-only carrier
                sample(8'hEB);
                check_carrier(1'b0, "R2 ignored bits");
                check_cmds(0, "R2 ignored bits");
                sample(8'h10);
                check_carrier(1'b1, "R1 header only");
                check_cmds(0, "R1 header only");
                // R3 arm the window
                sample(8'h04);
                check_carrier(1'b1, "R3 arm");
                check_cmds(0, "R3 arm");
                for (int e = 1; e <= lim + 1; e++) begin
                    bit last;
                    last = (e == lim + 1);
                    tick();
                    if (e == 1) begin
                        // R3 a sample without preamble keeps the stamp
                        sample(8'h00);
                        check_carrier(1'b0, "R3 no-preamble sample");
                        check_cmds(0, "R3 no-preamble sample");
                    end
                    if (last && hdr_close) begin
                        sample(8'h14);
                        check_cmds(1, "R6 close with header");
                    end else begin
                        sample(8'h04);
                        check_cmds(last ? 2 : 0, last ? "R4/R5/R8 close" : "R4/R8 inside window");
                    end
                end
                // R4 fresh window right after close
                sample(8'h04);
                check_cmds(0, "R4 re-arm");
                repeat (lim + 1) tick();
                sample(8'h04);
                check_cmds(2, "R4/R5 second close");
            end
        end
        // R7 back-pressure
        pre_ms = 8'd0;
        hdr_ms = 8'd0;
        do_reset();
        @(posedge clk); #1 cmd_ready = 1'b0;
        sample(8'h04);
        tick();
        sample(8'h04);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            total++;
            if (cmd_valid !== 1'b1 || cmd_byte !== 8'h02) begin
                bad++;
                $display("FAIL R7 stall actual valid=%0b byte=%h expected valid=1 byte=02",
                         cmd_valid, cmd_byte);
            end
        end
        @(posedge clk); #1 cmd_ready = 1'b1;
        check_cmds(2, "R7 after stall");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule